// File: doc/BRIEF.md
# Four-Slot Instruction Word Sequencer

The sequencer holds one fetched 18-bit instruction word and hands its packed 5-bit opcodes to an execution stage one per clock, from the top slot down. The word has four slots. The bottom slot has only three bits, so only opcodes whose two low bits are zero can sit there. The sequencer owns the program counter. It requests a new word after the last slot or after any control transfer, and waits for the memory to answer.

Branch opcodes form their target in a fixed way. The bits of the word below the branch opcode replace the same number of low bits of the already-incremented program counter, and the upper bits are kept. Return and execute take the target from the return-stack value. A micro-loop opcode re-runs the held word from slot 0 without a fetch while the loop count is non-zero. A literal opcode fetches the next memory word as data, and issue then resumes in the held word.

The execution stage, the stacks and the memory are outside the block. The loop count (`r_in`) and the top of stack (`t_in`) arrive as plain inputs, sampled in the cycle the opcode is issued.

Top module: `iws_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter is loaded with `RESET_PC` (default 10'h0AA). In the cycle after reset, `fetch_req` is 1, `fetch_is_data` is 0, `op_valid` is 0 and `branch_taken` is 0.
- R2: After a word is accepted, its slots are issued on consecutive cycles with `op_valid`=1, unless a control opcode intervenes. The slots are 0 (bits 17:13), 1 (bits 12:8), 2 (bits 7:3) and 3 (bits 2:0 shifted left by two, low bits zero). `slot` shows the slot index. After slot 3 of a plain opcode, the next cycle requests a fetch.
- R3: While `fetch_req` is 1, `op_valid` is 0, and the request and `fetch_addr` hold until a cycle with `fetch_valid`=1. That cycle accepts the word (or literal) on `fetch_word`.
- R4: Each accepted fetch advances the program counter as follows. If bit 8 is 1 (the I/O area), it is unchanged. Otherwise bits 6:0 increment modulo 128 and bits 9:7 are kept, so 0x07F goes to 0x000 and 0x0FF goes to 0x080.
- R5: Jump (5'd2) and call (5'd3) in slot 0, 1 or 2 load the program counter and request a fetch there. The target is the incremented counter with its low min(13,10), 8 or 3 bits replaced by the same low bits of the word.
- R6: Branch-if-zero (5'd6) is taken when `t_in`==0. Branch-if-non-negative (5'd7) is taken when `t_in[17]`==0. A taken branch splices its target as in R5. An untaken branch skips the rest of the word and fetches at the unchanged counter.
- R7: Return (5'd0) and execute (5'd1) load the program counter with `r_in[9:0]` and request a fetch.
- R8: Micro-loop (5'd4, allowed in slot 3) with `r_in`≠0 issues slot 0 of the same word next cycle, with no fetch. With `r_in`==0 it acts as a plain opcode.
- R9: Literal (5'd8, allowed in slot 3) makes the next cycle a data fetch: `fetch_req`=1 and `fetch_is_data`=1 at the counter. Acceptance advances the counter as in R4. Issue then resumes at the following slot, or a word fetch follows if the literal was in slot 3.
- R10: `branch_taken` is 1 for exactly the one cycle that follows the issue of a taken transfer (R5, taken R6, R7), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 18 | Word returned by memory |
| fetch_valid | input | 1 | Memory answers the pending request this cycle |
| r_in | input | 18 | Return-stack top: loop count and return address |
| t_in | input | 18 | Data-stack top for conditional branches |
| fetch_req | output | 1 | A fetch is pending at `fetch_addr` |
| fetch_addr | output | 10 | Program counter (next fetch address) |
| fetch_is_data | output | 1 | Pending fetch is a literal, not an instruction |
| op_valid | output | 1 | An opcode is issued this cycle |
| opcode | output | 5 | Issued opcode |
| slot | output | 2 | Slot index of the issued opcode |
| branch_taken | output | 1 | A transfer was taken in the previous cycle |

## Verification
All results come from registered state, so each one appears one clock after its cause. An accepted fetch shows slot 0 and the advanced counter on the next cycle. A transfer shows its target, `fetch_req` and `branch_taken` on the next cycle. A loop shows slot 0 again on the next cycle. The bench drives inputs on the falling edge and advances its reference model with those inputs once per cycle. It compares all outputs on the following falling edge, which is exactly one register stage after the edge that consumed the inputs.

// File: rtl/iws_pkg.sv
package iws_pkg;
  localparam int WORD_W     = 18;
  localparam int OP_W       = 5;
  localparam int SLOTS      = 4;
  localparam int SLOT_IDX_W = $clog2(SLOTS);
  localparam int TAIL_W     = WORD_W - OP_W * (SLOTS - 1);

  localparam logic [OP_W-1:0] OP_RET  = 5'd0;
  localparam logic [OP_W-1:0] OP_EXEC = 5'd1;
  localparam logic [OP_W-1:0] OP_JUMP = 5'd2;
  localparam logic [OP_W-1:0] OP_CALL = 5'd3;
  localparam logic [OP_W-1:0] OP_LOOP = 5'd4;
  localparam logic [OP_W-1:0] OP_BRZ  = 5'd6;
  localparam logic [OP_W-1:0] OP_BRNN = 5'd7;
  localparam logic [OP_W-1:0] OP_LIT  = 5'd8;

  typedef enum logic [2:0] {
    ACT_NEXT,    // plain opcode: advance slot
    ACT_TO_R,    // load counter from return value
    ACT_SPLICE,  // load counter from spliced target
    ACT_SKIP,    // drop rest of word, fetch at counter
    ACT_LOOP,    // restart slot 0, no fetch
    ACT_LIT      // fetch literal data
  } act_t;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_LIT,
    ST_ISSUE
  } state_t;
endpackage

// File: rtl/iws_slot_extract.sv
module iws_slot_extract
  import iws_pkg::*;
(
  input  logic [WORD_W-1:0]     word,
  input  logic [SLOT_IDX_W-1:0] sel,
  output logic [OP_W-1:0]       op
);
  logic [OP_W-1:0] ops [SLOTS];

  genvar k;
  generate
    for (k = 0; k < SLOTS - 1; k++) begin : g_full
      assign ops[k] = word[WORD_W-1-OP_W*k -: OP_W];
    end
  endgenerate

  assign ops[SLOTS-1] = {word[TAIL_W-1:0], {(OP_W-TAIL_W){1'b0}}};
  assign op = ops[sel];
endmodule

// File: rtl/iws_pc_unit.sv
module iws_pc_unit
  import iws_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int RGN_W  = 7,
  parameter int IO_BIT = 8
) (
  input  logic [PC_W-1:0]       p,
  input  logic [PC_W-1:0]       low_word,
  input  logic [SLOT_IDX_W-1:0] sel,
  output logic [PC_W-1:0]       p_inc,
  output logic [PC_W-1:0]       p_tgt
);
  logic [RGN_W-1:0] rgn_next;
  logic [PC_W-1:0]  tgt [SLOTS];

  assign rgn_next = p[RGN_W-1:0] + 1'b1;
  assign p_inc    = p[IO_BIT] ? p : {p[PC_W-1:RGN_W], rgn_next};

  genvar k;
  generate
    for (k = 0; k < SLOTS - 1; k++) begin : g_splice
      localparam int N = WORD_W - OP_W * (k + 1);
      localparam logic [PC_W-1:0] MASK =
        (N >= PC_W) ? {PC_W{1'b1}} : PC_W'((1 << N) - 1);
      assign tgt[k] = (p & ~MASK) | (low_word & MASK);
    end
  endgenerate

  assign tgt[SLOTS-1] = p;
  assign p_tgt = tgt[sel];
endmodule

// File: rtl/iws_branch_eval.sv
module iws_branch_eval
  import iws_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            t_zero,
  input  logic            t_neg,
  input  logic            r_nonzero,
  output act_t            act
);
  always_comb begin
    unique case (op)
      OP_RET, OP_EXEC: act = ACT_TO_R;
      OP_JUMP, OP_CALL: act = ACT_SPLICE;
      OP_BRZ:  act = t_zero ? ACT_SPLICE : ACT_SKIP;
      OP_BRNN: act = t_neg ? ACT_SKIP : ACT_SPLICE;
      OP_LOOP: act = r_nonzero ? ACT_LOOP : ACT_NEXT;
      OP_LIT:  act = ACT_LIT;
      default: act = ACT_NEXT;
    endcase
  end
endmodule

// File: rtl/iws_sequencer.sv
module iws_sequencer
  import iws_pkg::*;
#(
  parameter int              PC_W     = 10,
  parameter int              RGN_W    = 7,
  parameter int              IO_BIT   = 8,
  parameter logic [PC_W-1:0] RESET_PC = 10'h0AA
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     fetch_word,
  input  logic                  fetch_valid,
  input  logic [WORD_W-1:0]     r_in,
  input  logic [WORD_W-1:0]     t_in,
  output logic                  fetch_req,
  output logic [PC_W-1:0]       fetch_addr,
  output logic                  fetch_is_data,
  output logic                  op_valid,
  output logic [OP_W-1:0]       opcode,
  output logic [SLOT_IDX_W-1:0] slot,
  output logic                  branch_taken
);
  localparam logic [SLOT_IDX_W-1:0] LAST = SLOT_IDX_W'(SLOTS - 1);

  state_t                state_q;
  logic [PC_W-1:0]       p_q;
  logic [WORD_W-1:0]     word_q;
  logic [SLOT_IDX_W-1:0] slot_q;
  logic                  br_q;

  logic [OP_W-1:0] cur_op;
  logic [PC_W-1:0] p_inc, p_tgt;
  act_t            act;

  iws_slot_extract u_extract (
    .word (word_q),
    .sel  (slot_q),
    .op   (cur_op)
  );

  iws_pc_unit #(.PC_W(PC_W), .RGN_W(RGN_W), .IO_BIT(IO_BIT)) u_pc (
    .p        (p_q),
    .low_word (word_q[PC_W-1:0]),
    .sel      (slot_q),
    .p_inc    (p_inc),
    .p_tgt    (p_tgt)
  );

  iws_branch_eval u_eval (
    .op        (cur_op),
    .t_zero    (t_in == '0),
    .t_neg     (t_in[WORD_W-1]),
    .r_nonzero (r_in != '0),
    .act       (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      p_q     <= RESET_PC;
      word_q  <= '0;
      slot_q  <= '0;
      br_q    <= 1'b0;
    end else begin
      br_q <= 1'b0;
      unique case (state_q)
        ST_FETCH: begin
          if (fetch_valid) begin
            word_q  <= fetch_word;
            slot_q  <= '0;
            p_q     <= p_inc;
            state_q <= ST_ISSUE;
          end
        end
        ST_LIT: begin
          if (fetch_valid) begin
            p_q <= p_inc;
            if (slot_q == LAST) begin
              state_q <= ST_FETCH;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: begin
          unique case (act)
            ACT_TO_R: begin
              p_q     <= r_in[PC_W-1:0];
              br_q    <= 1'b1;
              state_q <= ST_FETCH;
            end
            ACT_SPLICE: begin
              p_q     <= p_tgt;
              br_q    <= 1'b1;
              state_q <= ST_FETCH;
            end
            ACT_SKIP: state_q <= ST_FETCH;
            ACT_LOOP: slot_q  <= '0;
            ACT_LIT:  state_q <= ST_LIT;
            default: begin
              if (slot_q == LAST) state_q <= ST_FETCH;
              else                slot_q  <= slot_q + 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  assign fetch_req     = (state_q != ST_ISSUE);
  assign fetch_is_data = (state_q == ST_LIT);
  assign fetch_addr    = p_q;
  assign op_valid      = (state_q == ST_ISSUE);
  assign opcode        = cur_op;
  assign slot          = slot_q;
  assign branch_taken  = br_q;

  // R1: first cycle out of reset is an instruction fetch at the reset address
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_req && !fetch_is_data && fetch_addr == RESET_PC && !branch_taken));

  // R2: a plain opcode in the last slot is followed by a word fetch
  p_last_slot_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && slot == LAST && opcode != OP_LIT && opcode != OP_RET &&
     !(opcode == OP_LOOP && r_in != '0)) |=> (fetch_req && !fetch_is_data));

  // R3: an unanswered request holds its address and kind
  p_hold_req_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_valid) |=>
      (fetch_req && $stable(fetch_addr) && $stable(fetch_is_data)));

  // R4: fetches in the I/O area leave the counter unchanged
  p_io_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_valid && fetch_addr[IO_BIT]) |=> (fetch_addr == $past(fetch_addr)));

  // R8: a loop with non-zero count restarts slot 0 without a fetch
  p_loop_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode == OP_LOOP && r_in != '0) |=> (op_valid && slot == '0));

  // R10: a taken flag always coincides with a pending instruction fetch
  p_taken_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (fetch_req && !fetch_is_data));
endmodule

// File: tb/iws_sequencer_test.sv
`timescale 1ns/1ps
module iws_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] fetch_word = '0;
  logic        fetch_valid = 1'b0;
  logic [17:0] r_in = '0;
  logic [17:0] t_in = '0;
  logic        fetch_req, fetch_is_data, op_valid, branch_taken;
  logic [9:0]  fetch_addr;
  logic [4:0]  opcode;
  logic [1:0]  slot;

  localparam logic [9:0]  RST_PC = 10'h0AA;
  localparam logic [17:0] PLAIN  = {5'd9, 5'd10, 5'd11, 3'd3};

  iws_sequencer uut (
    .clk(clk), .rst(rst), .fetch_word(fetch_word), .fetch_valid(fetch_valid),
    .r_in(r_in), .t_in(t_in), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_is_data(fetch_is_data), .op_valid(op_valid), .opcode(opcode),
    .slot(slot), .branch_taken(branch_taken)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [17:0] mem [1024];

  // reference model state
  int          m_state;  // 0 fetch, 1 literal, 2 issue
  logic [9:0]  m_p;
  logic [17:0] m_word;
  logic [1:0]  m_slot;
  logic        m_br;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [4:0] m_op();
    case (m_slot)
      2'd0: return m_word[17:13];
      2'd1: return m_word[12:8];
      2'd2: return m_word[7:3];
      default: return {m_word[2:0], 2'b00};
    endcase
  endfunction

  function automatic logic [9:0] m_inc(logic [9:0] p);
    if (p[8]) return p;
    return {p[9:7], p[6:0] + 7'd1};
  endfunction

  function automatic logic [9:0] m_tgt(logic [9:0] p, logic [17:0] w, logic [1:0] s);
    case (s)
      2'd0: return w[9:0];
      2'd1: return {p[9:8], w[7:0]};
      2'd2: return {p[9:3], w[2:0]};
      default: return p;
    endcase
  endfunction

  task automatic m_advance();
    if (m_slot == 2'd3) m_state = 0;
    else m_slot = m_slot + 2'd1;
  endtask

  task automatic m_step();
    logic taken = 1'b0;
    logic [4:0] op;
    case (m_state)
      0: if (fetch_valid) begin
        m_word = fetch_word; m_slot = 2'd0; m_p = m_inc(m_p); m_state = 2;
      end
      1: if (fetch_valid) begin
        m_p = m_inc(m_p);
        if (m_slot == 2'd3) m_state = 0;
        else begin m_slot = m_slot + 2'd1; m_state = 2; end
      end
      default: begin
        op = m_op();
        case (op)
          5'd0, 5'd1: begin m_p = r_in[9:0]; taken = 1'b1; m_state = 0; end
          5'd2, 5'd3: begin m_p = m_tgt(m_p, m_word, m_slot); taken = 1'b1; m_state = 0; end
          5'd6: begin
            if (t_in == 18'd0) begin m_p = m_tgt(m_p, m_word, m_slot); taken = 1'b1; end
            m_state = 0;
          end
          5'd7: begin
            if (!t_in[17]) begin m_p = m_tgt(m_p, m_word, m_slot); taken = 1'b1; end
            m_state = 0;
          end
          5'd4: if (r_in != 18'd0) m_slot = 2'd0; else m_advance();
          5'd8: m_state = 1;
          default: m_advance();
        endcase
      end
    endcase
    m_br = taken;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "fetch_req", int'(fetch_req), (m_state != 2) ? 1 : 0);
    chk(tag, "fetch_is_data", int'(fetch_is_data), (m_state == 1) ? 1 : 0);
    chk(tag, "op_valid", int'(op_valid), (m_state == 2) ? 1 : 0);
    chk(tag, "fetch_addr", int'(fetch_addr), int'(m_p));
    chk(tag, "branch_taken", int'(branch_taken), int'(m_br));
    if (m_state == 2) begin
      chk(tag, "opcode", int'(opcode), int'(m_op()));
      chk(tag, "slot", int'(slot), int'(m_slot));
    end
  endtask

  task automatic run_case(string tag, int lat, logic [17:0] t, logic [17:0] r, int ncyc);
    int  wcnt = 0;
    bit  pend = 0;
    @(negedge clk);
    rst = 1'b1; fetch_valid = 1'b0; t_in = t; r_in = r;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_state = 0; m_p = RST_PC; m_word = '0; m_slot = 2'd0; m_br = 1'b0;
    // R1: state right after reset
    chk({tag, " R1"}, "reset fetch_req", int'(fetch_req), 1);
    chk({tag, " R1"}, "reset fetch_addr", int'(fetch_addr), int'(RST_PC));
    for (int i = 0; i < ncyc; i++) begin
      if (pend) begin r_in = r_in - 18'd1; pend = 0; end
      compare(tag);
      if (m_state == 2 && m_op() == 5'd4 && r_in != 18'd0) pend = 1;
      if (fetch_req) begin
        if (wcnt >= lat) begin
          fetch_valid = 1'b1; fetch_word = mem[fetch_addr]; wcnt = 0;
        end else begin
          fetch_valid = 1'b0; wcnt++;
        end
      end else begin
        fetch_valid = 1'b0; wcnt = 0;
      end
      m_step();
      @(negedge clk);
    end
    fetch_valid = 1'b0;
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 1024; a++) mem[a] = PLAIN;
  endtask

  initial begin
    clear_mem();
    // R2: slot order with a full-range pattern, slot 3 = field << 2
    mem[RST_PC] = {5'd13, 5'd20, 5'd31, 3'd7};
    run_case("R2 slot order", 0, 18'd0, 18'd0, 16);
    // R3: request held across memory wait states
    run_case("R3 latency 2", 2, 18'd0, 18'd0, 30);
    run_case("R3 latency 5", 5, 18'd0, 18'd0, 30);
    // R4: region wraps and I/O area
    mem[RST_PC] = {5'd2, 13'h07F};
    run_case("R4 RAM wrap", 0, 18'd0, 18'd0, 16);
    mem[RST_PC] = {5'd2, 13'h0FF};
    run_case("R4 ROM wrap", 1, 18'd0, 18'd0, 16);
    mem[RST_PC] = {5'd2, 13'h1F0};
    run_case("R4 IO hold", 0, 18'd0, 18'd0, 16);
    // R5 R10: call in slot 1, jump in slot 2
    mem[RST_PC] = {5'd9, 5'd3, 8'h35};
    mem[10'h035] = {5'd9, 5'd10, 5'd2, 3'h5};
    run_case("R5 R10 splice", 0, 18'd0, 18'd0, 30);
    clear_mem();
    // R6: conditional branches both ways
    mem[RST_PC] = {5'd6, 13'h040};
    run_case("R6 brz taken", 0, 18'd0, 18'd0, 12);
    run_case("R6 brz not taken", 0, 18'd5, 18'd0, 12);
    mem[RST_PC] = {5'd10, 5'd7, 8'h21};
    run_case("R6 brnn not taken", 0, 18'h20000, 18'd0, 12);
    run_case("R6 brnn taken", 0, 18'd1, 18'd0, 12);
    // R7: return and execute
    mem[RST_PC] = {5'd9, 5'd0, 5'd10, 3'd3};
    run_case("R7 return", 0, 18'd0, 18'h00123, 12);
    mem[RST_PC] = {5'd1, 5'd9, 5'd10, 3'd3};
    run_case("R7 execute", 1, 18'd0, 18'h002F0, 12);
    // R8: micro-loop in slot 2 and in slot 3
    mem[RST_PC] = {5'd9, 5'd10, 5'd4, 3'd3};
    run_case("R8 loop slot2", 0, 18'd0, 18'd3, 24);
    mem[RST_PC] = {5'd9, 5'd10, 5'd11, 3'd1};
    run_case("R8 loop slot3", 0, 18'd0, 18'd2, 24);
    // R9: literal in slot 1 and slot 3
    mem[RST_PC] = {5'd9, 5'd8, 5'd10, 3'd2};
    mem[RST_PC + 10'd1] = 18'h3FFFF;
    run_case("R9 literal", 1, 18'd0, 18'd0, 24);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule